// File: doc/BRIEF.md
# Multiscale local-maxima scalogram generator

This block takes a stream of 12-bit samples, one per clock, and produces one scalogram column per clock for the sample at the centre of a sliding window. The window size (the scale) is fixed when the block is built. For a scale S the column has L = (S-1)/2 rows, and the window holds 2L+1 samples: L on each side of the centre.

Row k (1 to L) compares the centre sample against the two samples k positions before and k positions after it. When the centre is a strict extremum at that distance, the row entry is exactly zero. In every other case the entry is a fixed-point value strictly between 1 and 2, and a new value is drawn from a per-row pseudo-random source on every clock. A later stage can then find peaks as columns whose entries have zero variance, because a column of all zeros is constant and any failed row adds random spread.

Two mode inputs set the comparison. One selects maxima or minima detection. The other selects whether samples are read as two's-complement or as unsigned values. The block does not compute variance statistics and does not choose a scale by itself.

Top module: `scalogram_column`

## Requirements
- R1: While the synchronous active-high reset is applied, col_valid is 0 and every bit of col_data is 0.
- R2: One sample is loaded at every clock edge. The first sample loaded after reset is the one present at the first edge with rst low. col_valid is 0 until the edge after the one that loads the (2L+1)th sample, and is 1 from that edge on. The column presented after edge m describes the sample loaded at edge m-1-L (the centre). For row k, the earlier neighbour is the sample loaded at edge m-1-L-k and the later neighbour is the sample loaded at edge m-1-L+k.
- R3: With find_min = 0 (maxima), row k is exactly zero if and only if the centre is strictly greater than both of its distance-k neighbours.
- R4: With find_min = 1 (minima), row k is exactly zero if and only if the centre is strictly less than both of its distance-k neighbours.
- R5: A neighbour equal to the centre fails the comparison, so that row carries a nonzero entry.
- R6: Row k sits in col_data bits [(k-1)*17 +: 17]. A nonzero entry has bit 16 (the integer bit) set to 1 and a nonzero 16-bit fraction in bits 15:0, so its value lies strictly between 1 and 2.
- R7: Each row draws a new random value every clock, so two nonzero entries of the same row in consecutive clocks always differ.
- R8: With is_signed = 1, samples are compared as two's-complement numbers. With is_signed = 0, they are compared as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | DATA_W (12) | New sample, loaded every clock |
| is_signed | input | 1 | 1: compare as two's complement, 0: compare as unsigned |
| find_min | input | 1 | 0: maxima detection, 1: minima detection |
| col_valid | output | 1 | High when col_data holds a column for a fully windowed centre |
| col_data | output | L*17 (272) | Scalogram column, row k in bits [(k-1)*17 +: 17] |

## Verification
The bench feeds a pseudo-random stream in maxima mode and in minima mode. This tells whether the comparison direction and the neighbour distance of each row are correct. A constant stream and a stream of small repeating values make equal neighbours common, which separates strict from non-strict comparison. An isolated full-scale spike on a zero background is an extremum of opposite kinds under signed and unsigned reading, so it exposes a wrong sign interpretation. Each phase starts from reset, which exercises the window-fill delay before the first valid column. Comparing consecutive columns shows whether the random entries are drawn fresh each clock.

// File: rtl/scalogram_pkg.sv
package scalogram_pkg;

    localparam int FRAC_BITS = 16;
    localparam logic [FRAC_BITS-1:0] LFSR_TAPS = 16'hB400;

    typedef enum logic {
        EDGE_MAX = 1'b0,
        EDGE_MIN = 1'b1
    } edge_e;

    typedef struct packed {
        logic                 whole;
        logic [FRAC_BITS-1:0] frac;
    } fix_t;

    localparam int ENTRY_W = $bits(fix_t);

    function automatic logic [FRAC_BITS-1:0] lfsr_step(input logic [FRAC_BITS-1:0] s);
        logic [FRAC_BITS-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_TAPS;
        return n;
    endfunction

    function automatic logic [FRAC_BITS-1:0] row_seed(input int k);
        logic [FRAC_BITS-1:0] s;
        s = 16'hACE1 ^ FRAC_BITS'(k * 40503);
        if (s == '0) s = 16'h0001;
        return s;
    endfunction

    function automatic fix_t to_fix(input logic [FRAC_BITS-1:0] bits);
        fix_t f;
        f.whole = 1'b1;
        f.frac  = (bits == '0) ? FRAC_BITS'(1) : bits;
        return f;
    endfunction

endpackage

// File: rtl/sample_window.sv
module sample_window #(
    parameter int DATA_W = 12,
    parameter int WIN    = 33
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DATA_W-1:0]          sample_in,
    output logic [WIN-1:0][DATA_W-1:0] taps,
    output logic                       fill_done
);
    localparam int CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIN);

    logic [CNT_W-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps     <= '0;
            fill_cnt <= '0;
        end else begin
            taps[0] <= sample_in;
            for (int j = 1; j < WIN; j++) taps[j] <= taps[j-1];
            if (fill_cnt != FULL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    assign fill_done = (fill_cnt == FULL);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> taps[0] == $past(sample_in));

    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> taps[WIN-1] == $past(taps[WIN-2]));

endmodule

// File: rtl/scalogram_row.sv
module scalogram_row
    import scalogram_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter logic [FRAC_BITS-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] centre,
    input  logic [DATA_W-1:0] early,
    input  logic [DATA_W-1:0] late,
    input  logic              is_signed,
    input  edge_e             mode,
    output fix_t              entry
);
    logic [FRAC_BITS-1:0] lfsr_q;
    logic signed [DATA_W:0] cx, ex, lx;
    logic hit;

    always_comb begin
        cx = is_signed ? {centre[DATA_W-1], centre} : {1'b0, centre};
        ex = is_signed ? {early[DATA_W-1], early}   : {1'b0, early};
        lx = is_signed ? {late[DATA_W-1], late}     : {1'b0, late};
        if (mode == EDGE_MIN) hit = (cx < ex) && (cx < lx);
        else                  hit = (cx > ex) && (cx > lx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
            entry  <= '0;
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
            entry  <= hit ? fix_t'('0) : to_fix(lfsr_q);
        end
    end

    p_entry_code_r6: assert property (@(posedge clk) disable iff (rst)
        (entry == fix_t'('0)) || (entry.whole && entry.frac != '0));

    p_fresh_draw_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> lfsr_q != $past(lfsr_q));

    p_lfsr_live_r7: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/scalogram_column.sv
module scalogram_column
    import scalogram_pkg::*;
#(
    parameter int SCALE  = 33,
    parameter int DATA_W = 12,
    localparam int ROWS  = (SCALE - 1) / 2,
    localparam int WIN   = 2 * ROWS + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DATA_W-1:0]       sample_in,
    input  logic                    is_signed,
    input  logic                    find_min,
    output logic                    col_valid,
    output logic [ROWS*ENTRY_W-1:0] col_data
);
    logic [WIN-1:0][DATA_W-1:0] taps;
    logic  fill_done;
    edge_e mode;

    assign mode = edge_e'(find_min);

    sample_window #(.DATA_W(DATA_W), .WIN(WIN)) u_window (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .taps      (taps),
        .fill_done (fill_done)
    );

    for (genvar k = 1; k <= ROWS; k++) begin : g_row
        fix_t ent;
        scalogram_row #(.DATA_W(DATA_W), .SEED(row_seed(k))) u_row (
            .clk       (clk),
            .rst       (rst),
            .centre    (taps[ROWS]),
            .early     (taps[ROWS+k]),
            .late      (taps[ROWS-k]),
            .is_signed (is_signed),
            .mode      (mode),
            .entry     (ent)
        );
        assign col_data[(k-1)*ENTRY_W +: ENTRY_W] = ent;
    end

    always_ff @(posedge clk) begin
        if (rst) col_valid <= 1'b0;
        else     col_valid <= fill_done;
    end

    p_no_early_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !fill_done |=> !col_valid);

    p_valid_holds_r2: assert property (@(posedge clk) disable iff (rst)
        col_valid |=> col_valid);

endmodule

// File: tb/scalogram_column_tb.sv
`timescale 1ns/1ps
module scalogram_column_tb;
    localparam int SCALE = 33;
    localparam int L     = (SCALE - 1) / 2;
    localparam int EW    = 17;
    localparam int HMAX  = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [11:0] sample_in = '0;
    logic is_signed = 1'b0;
    logic find_min  = 1'b0;
    logic col_valid;
    logic [L*EW-1:0] col_data;

    int errors = 0;
    int checks = 0;
    logic [11:0] hist [HMAX];
    logic [L-1:0] exp_q [$];
    logic [L*EW-1:0] prev_data;
    bit prev_ok;
    int unsigned lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    scalogram_column #(.SCALE(SCALE), .DATA_W(12)) u_dut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .is_signed(is_signed),
        .find_min(find_min), .col_valid(col_valid), .col_data(col_data)
    );

    function automatic int sval(logic [11:0] x, bit sg);
        if (sg) return int'($signed(x));
        return int'({20'b0, x});
    endfunction

    function automatic logic [L-1:0] peak_mask(int n, bit sg, bit mn);
        logic [L-1:0] m;
        int c, e, l;
        c = sval(hist[n-L], sg);
        for (int k = 1; k <= L; k++) begin
            e = sval(hist[n-L-k], sg);
            l = sval(hist[n-L+k], sg);
            m[k-1] = mn ? (c < e && c < l) : (c > e && c > l);
        end
        return m;
    endfunction

    function automatic logic [11:0] gen(int kind, int i);
        case (kind)
            0: begin lcg = lcg * 1103515245 + 12345; return lcg[27:16]; end
            1: return 12'h5A5;
            2: return (i % 40 == 20) ? 12'hFFF : 12'h000;
            default: return 12'((i * 7) % 5);
        endcase
    endfunction

    task automatic check_col(string tag, int m);
        logic [L-1:0] mask;
        logic [EW-1:0] got, prv;
        bit ok_val, ok_fmt, ok_new;
        int badk;
        checks++;
        if (col_valid !== (m >= 2*L+1)) begin
            errors++;
            $display("FAIL R2 after edge %0d: col_valid=%b expected %b", m, col_valid, (m >= 2*L+1));
        end
        if (col_valid !== 1'b1) begin prev_ok = 0; return; end
        if (exp_q.size() == 0) begin
            errors++; checks++;
            $display("FAIL R2 after edge %0d: column present, none expected (actual %b expected 0)", m, col_valid);
            return;
        end
        mask = exp_q.pop_front();
        ok_val = 1; ok_fmt = 1; ok_new = 1; badk = 0;
        for (int k = 1; k <= L; k++) begin
            got = col_data[(k-1)*EW +: EW];
            prv = prev_data[(k-1)*EW +: EW];
            if (mask[k-1]) begin
                if (got !== '0 && ok_val) begin ok_val = 0; badk = k; end
            end else begin
                if (got === '0 && ok_val) begin ok_val = 0; badk = k; end
                else if ((got[16] !== 1'b1 || got[15:0] === '0) && ok_fmt) begin ok_fmt = 0; badk = k; end
                else if (prev_ok && prv !== '0 && got === prv && ok_new) begin ok_new = 0; badk = k; end
            end
        end
        checks += 2;
        if (!ok_val) begin
            errors++;
            $display("FAIL %s edge %0d row %0d: entry %h, expected zero=%b", tag, m, badk,
                     col_data[(badk-1)*EW +: EW], mask[badk-1]);
        end
        if (!ok_fmt) begin
            errors++;
            $display("FAIL R6 edge %0d row %0d: entry %h, expected 1.xxxx with nonzero fraction", m, badk,
                     col_data[(badk-1)*EW +: EW]);
        end
        if (!ok_new) begin
            errors++;
            $display("FAIL R7 edge %0d row %0d: entry %h equals previous %h, expected a new draw", m, badk,
                     col_data[(badk-1)*EW +: EW], prev_data[(badk-1)*EW +: EW]);
        end
        prev_data = col_data;
        prev_ok = 1;
    endtask

    task automatic run_phase(string tag, bit sg, bit mn, int kind, int n);
        @(negedge clk);
        rst = 1'b1;
        is_signed = sg;
        find_min = mn;
        repeat (2) @(negedge clk);
        checks++;
        if (col_valid !== 1'b0 || col_data !== '0) begin
            errors++;
            $display("FAIL R1 in reset: col_valid=%b col_data=%h, expected 0 and 0", col_valid, col_data);
        end
        exp_q.delete();
        prev_ok = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                @(negedge clk);
                check_col(tag, i - 1);
            end
            rst = 1'b0;
            hist[i] = gen(kind, i);
            sample_in = hist[i];
            if (i >= 2*L) exp_q.push_back(peak_mask(i, sg, mn));
        end
    endtask

    initial begin
        run_phase("R3", 1'b0, 1'b0, 0, 200);
        run_phase("R4", 1'b0, 1'b1, 0, 200);
        run_phase("R5", 1'b0, 1'b0, 1, 80);
        run_phase("R5", 1'b0, 1'b1, 3, 120);
        run_phase("R5", 1'b0, 1'b0, 3, 120);
        run_phase("R8", 1'b0, 1'b0, 2, 160);
        run_phase("R8", 1'b1, 1'b0, 2, 160);
        run_phase("R8", 1'b1, 1'b1, 2, 160);
        run_phase("R8", 1'b1, 1'b0, 0, 200);
        run_phase("R8", 1'b1, 1'b1, 0, 200);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule